// File: doc/BRIEF.md
# Hamming Single-Error-Correcting Byte Codec

This block protects one byte held in a storage array. On the write side it spreads the eight data bits over a twelve-position Hamming word and inserts four check bits at the power-of-two positions. When double-error detection is enabled, it also sets a thirteenth bit that gives the whole word even parity. On the read side it recomputes the checks over the stored word and forms a syndrome. A nonzero syndrome is the position number of the failing bit, and that bit is inverted before the data is extracted.

A mode input selects the plain single-error-correcting behaviour or the single-error-correcting, double-error-detecting behaviour. The decode side reports the corrected byte, an error flag and an uncorrectable flag. Both paths share one register stage, so results appear one clock after the inputs are sampled.

Top module: `hamCodec`

## Requirements
- R1: Codeword bit index i-1 holds position i (positions 1 to 12). The data bits D1..D8 (D1 = `encData[0]`) occupy positions 3, 5, 6, 7, 9, 10, 11 and 12 in that order. The check bits occupy positions 1, 2, 4 and 8.
- R2: The check bits are: position 1 = D1^D2^D4^D5^D7, position 2 = D1^D3^D4^D6^D7, position 4 = D2^D3^D4^D8, position 8 = D5^D6^D7^D8.
- R3: Data 8'h39 encodes to 12'h34F in the low twelve bits of `encCode`.
- R4: When `modeSecded`=1, `encCode[12]` makes the XOR of all 13 bits zero. When `modeSecded`=0, `encCode[12]` is 0.
- R5: In either mode, a word with exactly one inverted bit among positions 1..12 decodes to the original byte with `decErr`=1 and `decUncorr`=0.
- R6: The syndrome is ordered with the position-8 check as the MSB down to the position-1 check. For example, the word for 8'h39 with position 6 inverted decodes back to 8'h39.
- R7: When `modeSecded`=0, `decCode[12]` has no effect on any decode output.
- R8: When `modeSecded`=0, a syndrome of 13..15 gives `decErr`=1 and `decUncorr`=1, and the data bits are passed uncorrected.
- R9: When `modeSecded`=1, two inverted bits give `decErr`=1 and `decUncorr`=1, and the data bits are passed uncorrected.
- R10: When `modeSecded`=1, an inversion of `decCode[12]` alone gives `decErr`=1 and `decUncorr`=0, and the data is unchanged.
- R11: A valid codeword gives `decErr`=0, `decUncorr`=0 and the stored byte. `decUncorr`=1 never occurs without `decErr`=1.
- R12: All outputs are 0 while `rstN` is low. After reset, the outputs reflect the inputs sampled at the previous rising clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| modeSecded | input | 1 | 1 = add overall parity and detect double errors |
| encData | input | 8 | Byte to encode |
| encCode | output | 13 | Encoded word, bit 12 = overall parity |
| decCode | input | 13 | Stored word to check |
| decData | output | 8 | Corrected byte |
| decErr | output | 1 | Any error seen |
| decUncorr | output | 1 | Error that could not be corrected |

## Verification
The bench inverts each of the twelve positions in both modes. A design with a mis-ordered syndrome or data map would then return a byte with a different bit flipped. Every double inversion is applied in double-detect mode, where a design that ignored the parity bit would miscorrect and clear the uncorrectable flag. Other directed cases cover an inversion of only the parity bit, which a wrong design would treat as a data fault or as a double fault, and the syndrome 13 case in plain mode, which a naive design would try to correct at a position that does not exist. In plain mode the parity bit is driven to both values, and a design that did not ignore it would raise a false error.

// File: rtl/hamPkg.sv
package hamPkg;

  // Number of check bits needed so that every position has a syndrome code
  function automatic int checkCount(input int dataW);
    int r;
    r = 0;
    while ((1 << r) < dataW + r + 1) r++;
    return r;
  endfunction

  function automatic bit isPow2(input int p);
    return (p & (p - 1)) == 0;
  endfunction

  // Strobes from the control decision to the datapath
  typedef struct packed {
    logic fixEn;    // invert the position named by the syndrome
    logic errFlag;
    logic uncFlag;
  } ctlStrobes_t;

endpackage

// File: rtl/hamDatapath.sv
module hamDatapath
  import hamPkg::*;
#(
  parameter int DATA_W = 8,
  parameter int SYN_W  = checkCount(DATA_W),
  parameter int CODE_W = DATA_W + SYN_W
) (
  input  logic              modeSecded,
  input  logic [DATA_W-1:0] encData,
  output logic [CODE_W:0]   encWord,
  input  logic [CODE_W:0]   decCode,
  input  ctlStrobes_t       strobes,
  output logic [SYN_W-1:0]  syndrome,
  output logic              parityBad,
  output logic [DATA_W-1:0] fixData
);

  logic [CODE_W-1:0] spread;
  logic [SYN_W-1:0]  encChk;
  logic [CODE_W-1:0] flipMask;
  logic [CODE_W-1:0] fixedWord;

  // place data bits on the non-power-of-two positions
  always_comb begin
    int di;
    di = 0;
    spread = '0;
    for (int p = 1; p <= CODE_W; p++) begin
      if (!isPow2(p)) begin
        spread[p-1] = encData[di];
        di++;
      end
    end
  end

  // each check covers every position whose number has its bit set
  always_comb begin
    for (int j = 0; j < SYN_W; j++) begin
      encChk[j]   = 1'b0;
      syndrome[j] = 1'b0;
      for (int p = 1; p <= CODE_W; p++) begin
        if (((p >> j) & 1) == 1) begin
          encChk[j]   = encChk[j] ^ spread[p-1];
          syndrome[j] = syndrome[j] ^ decCode[p-1];
        end
      end
    end
  end

  always_comb begin
    encWord = {1'b0, spread};
    for (int j = 0; j < SYN_W; j++) encWord[(1 << j) - 1] = encChk[j];
    encWord[CODE_W] = modeSecded & (^encWord[CODE_W-1:0]);
  end

  assign parityBad = modeSecded & (^decCode);

  always_comb begin
    flipMask = '0;
    if (strobes.fixEn) begin
      for (int p = 1; p <= CODE_W; p++) begin
        if (p == int'(syndrome)) flipMask[p-1] = 1'b1;
      end
    end
  end

  assign fixedWord = decCode[CODE_W-1:0] ^ flipMask;

  always_comb begin
    int di;
    di = 0;
    fixData = '0;
    for (int p = 1; p <= CODE_W; p++) begin
      if (!isPow2(p)) begin
        fixData[di] = fixedWord[p-1];
        di++;
      end
    end
  end

endmodule

// File: rtl/hamControl.sv
module hamControl
  import hamPkg::*;
#(
  parameter int SYN_W  = 4,
  parameter int CODE_W = 12
) (
  input  logic             modeSecded,
  input  logic [SYN_W-1:0] syndrome,
  input  logic             parityBad,
  output ctlStrobes_t      strobes
);

  logic synNz;
  logic inRange;
  logic unc;

  assign synNz   = |syndrome;
  assign inRange = int'(syndrome) <= CODE_W;
  // out-of-range position, or a nonzero syndrome with good overall parity
  assign unc     = synNz & (!inRange | (modeSecded & !parityBad));

  always_comb begin
    strobes.fixEn   = synNz & !unc;
    strobes.errFlag = synNz | parityBad;
    strobes.uncFlag = unc;
  end

endmodule

// File: rtl/hamCodec.sv
module hamCodec
  import hamPkg::*;
#(
  parameter int DATA_W  = 8,
  parameter bit REG_OUT = 1'b1,
  localparam int SYN_W  = checkCount(DATA_W),
  localparam int CODE_W = DATA_W + SYN_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              modeSecded,
  input  logic [DATA_W-1:0] encData,
  output logic [CODE_W:0]   encCode,
  input  logic [CODE_W:0]   decCode,
  output logic [DATA_W-1:0] decData,
  output logic              decErr,
  output logic              decUncorr
);

  ctlStrobes_t       strobes;
  logic [SYN_W-1:0]  syndrome;
  logic              parityBad;
  logic [CODE_W:0]   encWord;
  logic [DATA_W-1:0] fixData;

  hamDatapath #(.DATA_W(DATA_W), .SYN_W(SYN_W), .CODE_W(CODE_W)) uDp (
    .modeSecded(modeSecded), .encData(encData), .encWord(encWord),
    .decCode(decCode), .strobes(strobes), .syndrome(syndrome),
    .parityBad(parityBad), .fixData(fixData)
  );

  hamControl #(.SYN_W(SYN_W), .CODE_W(CODE_W)) uCtl (
    .modeSecded(modeSecded), .syndrome(syndrome),
    .parityBad(parityBad), .strobes(strobes)
  );

  generate
    if (REG_OUT) begin : gReg
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          encCode   <= '0;
          decData   <= '0;
          decErr    <= 1'b0;
          decUncorr <= 1'b0;
        end else begin
          encCode   <= encWord;
          decData   <= fixData;
          decErr    <= strobes.errFlag;
          decUncorr <= strobes.uncFlag;
        end
      end
    end else begin : gComb
      always_comb begin
        encCode   = rstN ? encWord : '0;
        decData   = rstN ? fixData : '0;
        decErr    = rstN & strobes.errFlag;
        decUncorr = rstN & strobes.uncFlag;
      end
    end
  endgenerate

endmodule

// File: rtl/hamCodecChk.sv
module hamCodecChk #(
  parameter int CODE_W  = 12,
  parameter bit REG_OUT = 1'b1
) (
  input logic            clk,
  input logic            rstN,
  input logic            modeSecded,
  input logic [CODE_W:0] encCode,
  input logic            decErr,
  input logic            decUncorr
);

  assert_unc_has_err_R11: assert property (@(posedge clk) disable iff (!rstN)
    decUncorr |-> decErr);

  generate
    if (REG_OUT) begin : gSeq
      assert_even_parity_R4: assert property (@(posedge clk) disable iff (!rstN)
        $past(modeSecded) |-> (^encCode) == 1'b0);

      assert_sec_top_zero_R4: assert property (@(posedge clk) disable iff (!rstN)
        !$past(modeSecded) |-> !encCode[CODE_W]);

      assert_reset_clear_R12: assert property (@(posedge clk)
        !rstN |=> (encCode == '0 && !decErr && !decUncorr));
    end
  endgenerate

endmodule

bind hamCodec hamCodecChk #(.CODE_W(CODE_W), .REG_OUT(REG_OUT)) uChk (
  .clk(clk), .rstN(rstN), .modeSecded(modeSecded), .encCode(encCode),
  .decErr(decErr), .decUncorr(decUncorr)
);

// File: tb/tb_hamCodec.sv
module tb_hamCodec;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        modeSecded = 1'b0;
  logic [7:0]  encData = '0;
  logic [12:0] encCode;
  logic [12:0] decCode = '0;
  logic [7:0]  decData;
  logic        decErr;
  logic        decUncorr;

  int nChecks = 0;
  int nFails  = 0;

  hamCodec dut (
    .clk(clk), .rstN(rstN), .modeSecded(modeSecded), .encData(encData),
    .encCode(encCode), .decCode(decCode), .decData(decData),
    .decErr(decErr), .decUncorr(decUncorr)
  );

  always #(PERIOD/2) clk = ~clk;

  // reference encoder written from R1/R2/R4
  function automatic logic [12:0] refEnc(input logic [7:0] d, input logic sd);
    logic [11:0] c;
    c[0]  = d[0]^d[1]^d[3]^d[4]^d[6];
    c[1]  = d[0]^d[2]^d[3]^d[5]^d[6];
    c[2]  = d[0];
    c[3]  = d[1]^d[2]^d[3]^d[7];
    c[4]  = d[1];
    c[5]  = d[2];
    c[6]  = d[3];
    c[7]  = d[4]^d[5]^d[6]^d[7];
    c[8]  = d[4];
    c[9]  = d[5];
    c[10] = d[6];
    c[11] = d[7];
    return {sd & (^c), c};
  endfunction

  function automatic logic [7:0] refExtract(input logic [12:0] c);
    return {c[11], c[10], c[9], c[8], c[6], c[5], c[4], c[2]};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drive at a falling edge, result after the next rising edge
  task automatic step(input logic sd, input logic [7:0] d, input logic [12:0] code);
    modeSecded = sd;
    encData    = d;
    decCode    = code;
    @(negedge clk);
  endtask

  task automatic decCase(input string req, input logic sd, input logic [7:0] d,
                         input logic [12:0] flip, input logic eErr, input logic eUnc,
                         input logic eRaw);
    logic [12:0] w;
    w = refEnc(d, sd) ^ flip;
    step(sd, d, w);
    check(req, {23'd0, decData, decErr}, {23'd0, eRaw ? refExtract(w) : d, eErr});
    check(req, {31'd0, decUncorr}, {31'd0, eUnc});
  endtask

  // {mode, data, flip mask, expErr, expUnc, expRaw}
  localparam int NV = 11;
  localparam logic [24:0] VEC [NV] = '{
    {1'b0, 8'h39, 13'h0000, 1'b0, 1'b0, 1'b0},  // R11 clean
    {1'b0, 8'h39, 13'h0020, 1'b1, 1'b0, 1'b0},  // R6 position 6
    {1'b0, 8'hA5, 13'h0001, 1'b1, 1'b0, 1'b0},  // R5 position 1
    {1'b0, 8'h5A, 13'h0800, 1'b1, 1'b0, 1'b0},  // R5 position 12
    {1'b0, 8'hFF, 13'h1000, 1'b0, 1'b0, 1'b0},  // R7 top bit ignored
    {1'b0, 8'h00, 13'h0090, 1'b1, 1'b1, 1'b1},  // R8 syndrome 13
    {1'b1, 8'hC3, 13'h0000, 1'b0, 1'b0, 1'b0},  // R11 clean secded
    {1'b1, 8'h39, 13'h0020, 1'b1, 1'b0, 1'b0},  // R6 secded
    {1'b1, 8'h39, 13'h0204, 1'b1, 1'b1, 1'b1},  // R9 double
    {1'b1, 8'h7E, 13'h1000, 1'b1, 1'b0, 1'b0},  // R10 parity bit only
    {1'b1, 8'h12, 13'h0100, 1'b1, 1'b0, 1'b0}   // R5 position 9
  };

  initial begin
    #(PERIOD * 200000);
    nFails++;
    nChecks++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    // R12 reset state, inputs nonzero
    encData = 8'hFF; decCode = 13'h1FFF; modeSecded = 1'b1;
    repeat (3) @(negedge clk);
    check("R12 reset enc", {19'd0, encCode}, 32'd0);
    check("R12 reset dec", {22'd0, decData, decErr, decUncorr}, 32'd0);
    rstN = 1'b1;
    @(negedge clk);

    // R3 worked example
    step(1'b0, 8'h39, 13'h0);
    check("R3", {19'd0, encCode}, 32'h034F);
    step(1'b1, 8'h39, 13'h0);
    check("R4 secded top bit", {19'd0, encCode}, 32'h134F);

    // R12 latency: output holds until the next rising edge
    modeSecded = 1'b0; encData = 8'h01; decCode = '0;
    #1 check("R12 hold", {19'd0, encCode}, 32'h134F);
    @(negedge clk);
    check("R12 update", {19'd0, encCode}, {19'd0, refEnc(8'h01, 1'b0)});

    // vector table
    for (int i = 0; i < NV; i++) begin
      decCase("R5-table", VEC[i][24], VEC[i][23:16], VEC[i][15:3],
              VEC[i][2], VEC[i][1], VEC[i][0]);
    end

    // R1 R2 R4: every byte in both modes
    for (int d = 0; d < 256; d++) begin
      for (int m = 0; m < 2; m++) begin
        step(m[0], d[7:0], refEnc(d[7:0], m[0]));
        check("R1 R2 R4 encode", {19'd0, encCode}, {19'd0, refEnc(d[7:0], m[0])});
        check("R11 clean decode", {22'd0, decData, decErr, decUncorr},
              {22'd0, d[7:0], 2'b00});
      end
    end

    // R5: every single position, both modes
    for (int p = 0; p < 12; p++) begin
      for (int m = 0; m < 2; m++) begin
        decCase("R5 single", m[0], 8'h6B ^ p[7:0], 13'(1) << p, 1'b1, 1'b0, 1'b0);
      end
    end

    // R9: every double pair in secded mode
    for (int a = 0; a < 12; a++) begin
      for (int b = a + 1; b < 12; b++) begin
        decCase("R9 double", 1'b1, 8'h9C, (13'(1) << a) | (13'(1) << b), 1'b1, 1'b1, 1'b1);
      end
    end

    // R7: top bit both ways in SEC mode with a single error present
    decCase("R7 top set", 1'b0, 8'h44, 13'h1040, 1'b1, 1'b0, 1'b0);
    decCase("R7 top clr", 1'b0, 8'h44, 13'h0040, 1'b1, 1'b0, 1'b0);
    // R8: syndrome 15 (positions 7 and 8)
    decCase("R8 syndrome 15", 1'b0, 8'h21, 13'h00C0, 1'b1, 1'b1, 1'b1);
    // R10 second byte
    decCase("R10 parity only", 1'b1, 8'hE7, 13'h1000, 1'b1, 1'b0, 1'b0);

    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule